// File: doc/BRIEF.md
# Two-Lane Sample Deinterleaver

This block takes one stream of signed samples that arrives at the full conversion rate, one sample on every clock edge. It splits the stream onto two output buses, lane A and lane B. Each bus updates on every second edge. The samples alternate between the lanes in arrival order, the same way two converters would share the work if they ran on opposite halves of a divide-by-two encode clock. Each lane has its own ready strobe. A lane's data is held for two full cycles, so it is stable on both sides of the strobe.

Every sample crosses a fixed-length delay line, so the output lags the input by a number of clock edges that does not change. By default the lag is 40. Samples leave the block in twos complement. A per-sample flag marks input that is in offset binary. The block converts flagged samples by inverting the sign bit.

Top module: `dual_lane_splitter`

## Requirements
- R1: A sample taken at clock edge k appears on its lane bus exactly LAT edges later, after edge k+LAT (LAT defaults to 40). Before the first sample arrives there, both strobes stay low.
- R2: Counting samples from 1 after reset, odd-numbered samples go to lane A and even-numbered samples go to lane B.
- R3: When the offset flag is 0, the sample reaches the output bus bit for bit. Bit 0 is the LSB on both buses.
- R4: When the offset flag is 1, the output equals the input with only the MSB inverted. For example, 0x800 (midscale) becomes 0x000, 0xFFF becomes 0x7FF, and 0x000 becomes 0x800.
- R5: A lane bus changes only on the edge that raises its own strobe. It holds its value for the cycle in between.
- R6: Each strobe is high for one cycle at a time. The two strobes are never high together. Once the pipeline is full, a strobe on A is followed by a strobe on B, and a strobe on B is followed by a strobe on A.
- R7: While reset is asserted (rst_n low, asynchronous), both buses read 0 and both strobes are low.
- R8: The first sample taken after reset is released always lands on lane A, whatever the lane phase was before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_i | input | 12 | Incoming sample, taken on every rising edge |
| obin_i | input | 1 | 1 marks smp_i as offset binary, to be converted |
| lane_a_o | output | 12 | Lane A data, odd-numbered samples |
| lane_a_rdy_o | output | 1 | Lane A strobe, high for the cycle in which new data appears |
| lane_b_o | output | 12 | Lane B data, even-numbered samples |
| lane_b_rdy_o | output | 1 | Lane B strobe, high for the cycle in which new data appears |

## Verification
The bench counts rising edges from the release of reset. It expects the sample taken at edge k to appear after edge k+40. A strobe is due on lane A when k is odd and on lane B when k is even. Before that point, no strobe is expected. The outputs are read at the falling edge that follows each rising edge. The expected lane contents are kept in a 64-entry ring, indexed by edge number, so each compare sits in exactly the cycle its result is due. Resets during a run land on both lane phases. After each one, the bench checks that the outputs are zero at once and that the 40-edge count starts again on lane A.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;

    function automatic lane_e lane_other(input lane_e cur);
        return (cur == LANE_A) ? LANE_B : LANE_A;
    endfunction

endpackage

// File: rtl/dls_ingress.sv
module dls_ingress
    import dls_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic         obin_i,
    output logic [W+1:0] stage_o   // {valid, lane, data}
);
    localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        lane_e          phase;
        logic           vld;
        lane_e          lane;
        logic [W-1:0]   dat;
    } ing_t;

    ing_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b1;
        st_d.lane  = st_q.phase;
        st_d.dat   = obin_i ? (smp_i ^ SIGN_BIT) : smp_i;
        st_d.phase = lane_other(st_q.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= LANE_A;
            st_q.vld   <= 1'b0;
            st_q.lane  <= LANE_A;
            st_q.dat   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = {st_q.vld, st_q.lane, st_q.dat};

endmodule

// File: rtl/dls_delay.sv
module dls_delay #(
    parameter int W     = 14,
    parameter int DEPTH = 39
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [W-1:0] pipe_d [DEPTH];
    logic [W-1:0] pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = in_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign out_o = pipe_q[DEPTH-1];

endmodule

// File: rtl/dls_lane.sv
module dls_lane
    import dls_pkg::*;
#(
    parameter int    W    = 12,
    parameter lane_e LANE = LANE_A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W+1:0] stage_i,   // {valid, lane, data}
    output logic [W-1:0] dat_o,
    output logic         rdy_o
);
    typedef struct packed {
        logic         rdy;
        logic [W-1:0] dat;
    } lane_t;

    lane_t  ln_d, ln_q;
    logic   hit;

    always_comb begin
        hit    = stage_i[W+1] && (lane_e'(stage_i[W]) == LANE);
        ln_d   = ln_q;
        ln_d.rdy = hit;
        if (hit) begin
            ln_d.dat = stage_i[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign dat_o = ln_q.dat;
    assign rdy_o = ln_q.rdy;

endmodule

// File: rtl/dual_lane_splitter.sv
module dual_lane_splitter
    import dls_pkg::*;
#(
    parameter int W   = 12,
    parameter int LAT = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic         obin_i,
    output logic [W-1:0] lane_a_o,
    output logic         lane_a_rdy_o,
    output logic [W-1:0] lane_b_o,
    output logic         lane_b_rdy_o
);
    // one register at ingress, LAT-1 in the delay line, one at each lane
    localparam int DLY    = LAT - 1;
    localparam int SW     = W + 2;
    localparam int NLANES = 2;

    logic [SW-1:0] ing_stage;
    logic [SW-1:0] late_stage;
    logic [W-1:0]  lane_dat [NLANES];
    logic          lane_rdy [NLANES];

    dls_ingress #(.W(W)) u_ingress (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_i   (smp_i),
        .obin_i  (obin_i),
        .stage_o (ing_stage)
    );

    dls_delay #(.W(SW), .DEPTH(DLY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (ing_stage),
        .out_o (late_stage)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        dls_lane #(
            .W    (W),
            .LANE ((g == 0) ? LANE_A : LANE_B)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .stage_i (late_stage),
            .dat_o   (lane_dat[g]),
            .rdy_o   (lane_rdy[g])
        );
    end

    assign lane_a_o     = lane_dat[0];
    assign lane_a_rdy_o = lane_rdy[0];
    assign lane_b_o     = lane_dat[1];
    assign lane_b_rdy_o = lane_rdy[1];

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int W   = 12,
    parameter int LAT = 40
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] lane_a_o,
    input logic         lane_a_rdy_o,
    input logic [W-1:0] lane_b_o,
    input logic         lane_b_rdy_o
);
    localparam int            CW  = $clog2(LAT + 2);
    localparam logic [CW-1:0] LIM = CW'(LAT);

    logic [CW-1:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_q <= '0;
        end else if (edges_q <= LIM) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    // R1: nothing emerges before the first sample has crossed LAT edges
    assert_quiet_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q <= LIM) |-> !(lane_a_rdy_o || lane_b_rdy_o));

    // R1: once full, exactly one lane is strobed each cycle
    assert_steady_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q > LIM) |-> (lane_a_rdy_o ^ lane_b_rdy_o));

    // R6: the strobes never coincide
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lane_a_rdy_o, lane_b_rdy_o}));

    // R6: lane A is followed by lane B
    assert_a_then_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_a_rdy_o |=> lane_b_rdy_o);

    // R6: lane B is followed by lane A
    assert_b_then_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_b_rdy_o |=> lane_a_rdy_o);

    // R5: a bus moves only when its own strobe rises
    assert_hold_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_a_rdy_o |-> $stable(lane_a_o));

    assert_hold_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_b_rdy_o |-> $stable(lane_b_o));

endmodule

bind dual_lane_splitter dls_checker #(.W(W), .LAT(LAT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lane_a_o     (lane_a_o),
    .lane_a_rdy_o (lane_a_rdy_o),
    .lane_b_o     (lane_b_o),
    .lane_b_rdy_o (lane_b_rdy_o)
);

// File: tb/sim_dual_lane_splitter.sv
module sim_dual_lane_splitter;
    localparam int CLK_P = 10;
    localparam int W     = 12;
    localparam int LAT   = 40;
    localparam logic [W-1:0] MSB = 12'h800;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] smp = '0;
    logic         obin = 1'b0;
    logic [W-1:0] la, lb;
    logic         ra, rb;

    always #(CLK_P/2) clk = ~clk;

    dual_lane_splitter #(.W(W), .LAT(LAT)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_i        (smp),
        .obin_i       (obin),
        .lane_a_o     (la),
        .lane_a_rdy_o (ra),
        .lane_b_o     (lb),
        .lane_b_rdy_o (rb)
    );

    int           n_chk = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;
    int           m     = 0;        // rising edges since reset release
    logic [W-1:0] hist [64];
    bit           hflag [64];
    logic [W-1:0] ea = '0;
    logic [W-1:0] eb = '0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, m);
        end
    endtask

    // called just after a falling edge: check results of edge m, drive input for edge m+1
    task automatic step(input logic [W-1:0] v, input logic ob);
        int         k;
        logic [1:0] er;
        string      ta, tb, tr;
        k  = m - LAT;
        er = 2'b00;
        ta = "R5 hold lane A";
        tb = "R5 hold lane B";
        if (k >= 1) begin
            if (k % 2 == 1) begin
                ea = hist[k % 64];
                er = 2'b10;
                ta = hflag[k % 64] ? "R2 R4 lane A offset" : "R2 R3 lane A";
            end else begin
                eb = hist[k % 64];
                er = 2'b01;
                tb = hflag[k % 64] ? "R2 R4 lane B offset" : "R2 R3 lane B";
            end
        end
        if (k < 1)       tr = "R1 strobes during fill";
        else if (k == 1) tr = "R8 first sample on A";
        else             tr = "R6 strobe alternation";
        chk(tr, {14'b0, ra, rb}, {14'b0, er});
        chk(ta, {4'b0, la}, {4'b0, ea});
        chk(tb, {4'b0, lb}, {4'b0, eb});
        smp = v;
        obin = ob;
        hist[(m + 1) % 64]  = ob ? (v ^ MSB) : v;
        hflag[(m + 1) % 64] = ob;
        @(posedge clk);
        m++;
        @(negedge clk);
    endtask

    task automatic hit_reset(input int cyc);
        rst_n = 1'b0;
        #1;
        chk("R7 reset lane A", {4'b0, la}, 16'h0);
        chk("R7 reset lane B", {4'b0, lb}, 16'h0);
        chk("R7 reset strobes", {14'b0, ra, rb}, 16'h0);
        for (int i = 0; i < cyc; i++) @(negedge clk);
        chk("R7 reset held", {ra, rb, la, 2'b0}, 16'h0);
        rst_n = 1'b1;
        m  = 0;
        ea = '0;
        eb = '0;
    endtask

    initial begin
        @(negedge clk);
        hit_reset(3);
        // R3 R2: every code in twos complement, pass-through
        for (int i = 0; i < 4096 + LAT + 2; i++)
            step((i < 4096) ? W'(i) : W'(i * 7), 1'b0);
        // reset with lane phase at A-next after an even count
        hit_reset(2);
        // R4: every code marked offset binary, descending, odd drain length
        for (int i = 0; i < 4096 + LAT + 3; i++)
            step(W'(4095 - i), 1'b1);
        hit_reset(4);
        // R4 corner codes
        step(12'h800, 1'b1);
        step(12'hFFF, 1'b1);
        step(12'h000, 1'b1);
        step(12'h7FF, 1'b0);
        // mixed flags, scattered values
        for (int i = 0; i < 300; i++)
            step(W'(i * 1103 + 17), i[1]);
        // short reset in mid-stream, before the pipeline drains (R8)
        hit_reset(1);
        for (int i = 0; i < LAT + 20; i++)
            step(W'(i * 3 + 2048), i[0]);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule